// File: doc/BRIEF.md
# Divide Exception Flag Unit

This block sits next to a floating-point divider and decides which exception status bits a divide or reciprocal-estimate operation raises. For each accepted operation it classifies the two IEEE-754 operands from their exponent and fraction fields. From those classes it works out the zero-divide, invalid-operation and signaling-NaN events. It then updates a set of sticky status bits. It also produces two one-cycle enables: one that lets the result reach the destination register, and one that lets the result class field be updated.

A finite nonzero value divided by zero is a zero-divide. Zero divided by zero is an invalid operation, and the two are never reported together. A reciprocal estimate or reciprocal square-root estimate of a zero raises a zero-divide. When the trap enable for an event is set, the write enables are withheld, so the destination keeps its old value. The rounding flags come in from the datapath. They are loaded on ordinary operations and forced to zero when an exception event occurs.

Top module: `fdx_flag_unit`

## Requirements
- R1: Operands are classified from the exponent and fraction fields as follows. An all-ones exponent with a zero fraction is an infinity. An all-ones exponent with a nonzero fraction is a NaN: it is quiet when the top fraction bit is 1 and signaling when that bit is 0. A zero exponent with a zero fraction is a zero of either sign. Every other value, denormals included, is finite nonzero.
- R2: When `op_kind` is 2'b00 (divide), a finite nonzero dividend with a zero divisor sets `zx`.
- R3: When `op_kind` is 2'b01 (reciprocal estimate) or 2'b10 (reciprocal square-root estimate), a zero `divisor` operand sets `zx`. These operations ignore `dividend`.
- R4: In a divide, zero over zero of any signs sets `vx_zdz` and does not set `zx`. Infinity over infinity sets `vx_idi`.
- R5: A signaling NaN in any operand the operation uses sets `vx_snan`. If any NaN is present among the operands used, no zero-divide, 0/0, inf/inf or square-root event is raised.
- R6: A reciprocal square-root estimate of a negative operand that is finite nonzero, or of negative infinity, sets `vx_sqrt`.
- R7: `vx` is set whenever the operation raises any invalid event (signaling NaN, 0/0, inf/inf or square root).
- R8: `fx` is set by any operation that changes one of `zx`, `vx_snan`, `vx_zdz`, `vx_idi` or `vx_sqrt` from 0 to 1. All status bits except `fr` and `fi` are sticky and are cleared only by reset.
- R9: An accepted operation that raises a zero-divide or an invalid event clears `fr` and `fi`. Any other accepted operation loads them from `rnd_fr` and `rnd_fi`. Between operations they hold their value.
- R10: `dest_we` and `fprf_we` are asserted for exactly one cycle, in the cycle after an operation is accepted. Both stay low when `ve_en` is 1 and the operation raises an invalid event. Both also stay low when `ze_en` is 1 and the operation raises a zero-divide.
- R11: A cycle with `op_valid` low, or with `op_kind` 2'b11, changes no status bit and asserts no write enable.
- R12: Holding `rst_n` low through a rising clock edge clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 00 divide, 01 reciprocal estimate, 10 reciprocal square-root estimate, 11 none |
| dividend | input | EXP_W+FRAC_W+1 | Dividend operand (sign, exponent, fraction) |
| divisor | input | EXP_W+FRAC_W+1 | Divisor, or the sole operand of an estimate |
| ve_en | input | 1 | Invalid-operation trap enable |
| ze_en | input | 1 | Zero-divide trap enable |
| rnd_fr | input | 1 | Fraction-rounded flag from the datapath |
| rnd_fi | input | 1 | Inexact flag from the datapath |
| fx | output | 1 | Sticky exception summary |
| vx | output | 1 | Sticky invalid-operation summary |
| vx_snan | output | 1 | Sticky signaling-NaN invalid bit |
| vx_zdz | output | 1 | Sticky 0/0 invalid bit |
| vx_idi | output | 1 | Sticky inf/inf invalid bit |
| vx_sqrt | output | 1 | Sticky negative square-root invalid bit |
| zx | output | 1 | Sticky zero-divide bit |
| fr | output | 1 | Fraction-rounded flag |
| fi | output | 1 | Inexact flag |
| dest_we | output | 1 | Destination write enable, one-cycle pulse |
| fprf_we | output | 1 | Result-class field update enable, one-cycle pulse |

## Verification
The bench uses the default widths, EXP_W=11 and FRAC_W=52, so the operands are ordinary double-precision encodings. That makes it straightforward to build the cases that matter: signed zeros, the smallest denormal, infinities of both signs, and quiet and signaling NaNs. Directed sequences show that the sticky bits survive later operations, that the `fx` rise happens only on a first set, and how each trap enable withholds the writes. A mid-run reset is followed by a long series of mixed random operations, with the trap enables toggled, and every cycle is compared against a behavioural model.

// File: rtl/fdx_pkg.sv
package fdx_pkg;

    typedef enum logic [1:0] {
        OP_DIV       = 2'b00,
        OP_RECIP_EST = 2'b01,
        OP_RSQRT_EST = 2'b10,
        OP_NONE      = 2'b11
    } fdx_op_e;

    // Class of one operand; exactly one of zero/finite_nz/inf/qnan/snan is set.
    typedef struct packed {
        logic neg;
        logic zero;
        logic finite_nz;
        logic inf;
        logic qnan;
        logic snan;
    } fdx_class_t;

    // Events raised by a single operation.
    typedef struct packed {
        logic snan;
        logic zdz;
        logic idi;
        logic sqrt;
        logic zx;
        logic invalid;
    } fdx_event_t;

    // Registered state of the unit.
    typedef struct packed {
        logic fx;
        logic vx;
        logic vx_snan;
        logic vx_zdz;
        logic vx_idi;
        logic vx_sqrt;
        logic zx;
        logic fr;
        logic fi;
        logic dest_we;
        logic fprf_we;
    } fdx_state_t;

endpackage

// File: rtl/fdx_classify.sv
module fdx_classify
    import fdx_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output fdx_class_t            cls
);
    localparam int SIGN_BIT  = EXP_W + FRAC_W;
    localparam int QUIET_BIT = FRAC_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    assign exp_f   = operand[SIGN_BIT-1:FRAC_W];
    assign frac_f  = operand[FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;
    assign frac_nz = |frac_f;

    always_comb begin
        cls           = '0;
        cls.neg       = operand[SIGN_BIT];
        cls.zero      = exp_min && !frac_nz;
        cls.inf       = exp_max && !frac_nz;
        cls.qnan      = exp_max && frac_nz && frac_f[QUIET_BIT];
        cls.snan      = exp_max && frac_nz && !frac_f[QUIET_BIT];
        cls.finite_nz = !exp_max && !(exp_min && !frac_nz);
    end

endmodule

// File: rtl/fdx_event_decode.sv
module fdx_event_decode
    import fdx_pkg::*;
(
    input  fdx_op_e    kind,
    input  fdx_class_t cls_a,
    input  fdx_class_t cls_b,
    output fdx_event_t ev
);
    logic a_nan;
    logic b_nan;
    logic unused_dividend_sign;

    assign a_nan                = cls_a.qnan | cls_a.snan;
    assign b_nan                = cls_b.qnan | cls_b.snan;
    assign unused_dividend_sign = cls_a.neg;

    always_comb begin
        ev = '0;
        unique case (kind)
            OP_DIV: begin
                ev.snan = cls_a.snan | cls_b.snan;
                if (!(a_nan || b_nan)) begin
                    ev.zdz = cls_a.zero & cls_b.zero;
                    ev.idi = cls_a.inf & cls_b.inf;
                    ev.zx  = cls_a.finite_nz & cls_b.zero;
                end
            end
            OP_RECIP_EST: begin
                ev.snan = cls_b.snan;
                ev.zx   = cls_b.zero;
            end
            OP_RSQRT_EST: begin
                ev.snan = cls_b.snan;
                ev.zx   = cls_b.zero;
                ev.sqrt = cls_b.neg & (cls_b.finite_nz | cls_b.inf);
            end
            default: ev = '0;
        endcase
        ev.invalid = ev.snan | ev.zdz | ev.idi | ev.sqrt;
    end

endmodule

// File: rtl/fdx_flag_unit.sv
module fdx_flag_unit
    import fdx_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [1:0]             op_kind,
    input  logic [EXP_W+FRAC_W:0]  dividend,
    input  logic [EXP_W+FRAC_W:0]  divisor,
    input  logic                   ve_en,
    input  logic                   ze_en,
    input  logic                   rnd_fr,
    input  logic                   rnd_fi,
    output logic                   fx,
    output logic                   vx,
    output logic                   vx_snan,
    output logic                   vx_zdz,
    output logic                   vx_idi,
    output logic                   vx_sqrt,
    output logic                   zx,
    output logic                   fr,
    output logic                   fi,
    output logic                   dest_we,
    output logic                   fprf_we
);
    localparam int OPW    = EXP_W + FRAC_W + 1;
    localparam int N_OPND = 2;

    fdx_op_e    kind;
    logic       accept;
    fdx_class_t cls [N_OPND];
    logic [OPW-1:0] opnd [N_OPND];
    fdx_event_t ev;
    fdx_state_t st_d;
    fdx_state_t st_q;
    logic       first_set;
    logic       trapped;

    assign kind    = fdx_op_e'(op_kind);
    assign accept  = op_valid && (kind != OP_NONE);
    assign opnd[0] = dividend;
    assign opnd[1] = divisor;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fdx_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .operand (opnd[g]),
            .cls     (cls[g])
        );
    end

    fdx_event_decode u_dec (
        .kind  (kind),
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .ev    (ev)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dest_we = 1'b0;
        st_d.fprf_we = 1'b0;
        first_set    = (ev.snan & ~st_q.vx_snan) | (ev.zdz & ~st_q.vx_zdz)
                     | (ev.idi & ~st_q.vx_idi) | (ev.sqrt & ~st_q.vx_sqrt)
                     | (ev.zx & ~st_q.zx);
        trapped      = (ve_en & ev.invalid) | (ze_en & ev.zx);
        if (accept) begin
            st_d.vx_snan = st_q.vx_snan | ev.snan;
            st_d.vx_zdz  = st_q.vx_zdz | ev.zdz;
            st_d.vx_idi  = st_q.vx_idi | ev.idi;
            st_d.vx_sqrt = st_q.vx_sqrt | ev.sqrt;
            st_d.zx      = st_q.zx | ev.zx;
            st_d.vx      = st_q.vx | ev.invalid;
            st_d.fx      = st_q.fx | first_set;
            if (ev.zx || ev.invalid) begin
                st_d.fr = 1'b0;
                st_d.fi = 1'b0;
            end else begin
                st_d.fr = rnd_fr;
                st_d.fi = rnd_fi;
            end
            st_d.dest_we = !trapped;
            st_d.fprf_we = !trapped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fx      = st_q.fx;
    assign vx      = st_q.vx;
    assign vx_snan = st_q.vx_snan;
    assign vx_zdz  = st_q.vx_zdz;
    assign vx_idi  = st_q.vx_idi;
    assign vx_sqrt = st_q.vx_sqrt;
    assign zx      = st_q.zx;
    assign fr      = st_q.fr;
    assign fi      = st_q.fi;
    assign dest_we = st_q.dest_we;
    assign fprf_we = st_q.fprf_we;

endmodule

// File: rtl/fdx_flag_unit_chk.sv
module fdx_flag_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic op_valid,
    input logic ve_en,
    input logic ze_en,
    input logic ev_invalid,
    input logic ev_zx,
    input logic ev_zdz,
    input logic fx,
    input logic vx,
    input logic vx_snan,
    input logic vx_zdz,
    input logic vx_idi,
    input logic vx_sqrt,
    input logic zx,
    input logic fr,
    input logic fi,
    input logic dest_we,
    input logic fprf_we
);
    // R4
    zdz_not_zx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_zdz |-> !ev_zx);

    // R8
    zx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zx |=> zx);

    // R8
    vx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vx |=> vx);

    // R8
    fx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(zx) || $rose(vx_snan) || $rose(vx_zdz) || $rose(vx_idi) || $rose(vx_sqrt)) |-> fx);

    // R7
    vx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vx_snan || vx_zdz || vx_idi || vx_sqrt) |-> vx);

    // R9
    zx_clears_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zx) |-> (!fr && !fi));

    // R10
    ve_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ve_en && ev_invalid) |=> (!dest_we && !fprf_we));

    // R10
    ze_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ze_en && ev_zx) |=> (!dest_we && !fprf_we));

    // R11
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!dest_we && !fprf_we));

endmodule

bind fdx_flag_unit fdx_flag_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .ve_en      (ve_en),
    .ze_en      (ze_en),
    .ev_invalid (ev.invalid),
    .ev_zx      (ev.zx),
    .ev_zdz     (ev.zdz),
    .fx         (fx),
    .vx         (vx),
    .vx_snan    (vx_snan),
    .vx_zdz     (vx_zdz),
    .vx_idi     (vx_idi),
    .vx_sqrt    (vx_sqrt),
    .zx         (zx),
    .fr         (fr),
    .fi         (fi),
    .dest_we    (dest_we),
    .fprf_we    (fprf_we)
);

// File: tb/fdx_flag_unit_bench.sv
`timescale 1ns/1ps
module fdx_flag_unit_bench;

    localparam logic [63:0] C_P1   = 64'h3FF0000000000000;
    localparam logic [63:0] C_P2   = 64'h4000000000000000;
    localparam logic [63:0] C_N4   = 64'hC010000000000000;
    localparam logic [63:0] C_PZ   = 64'h0000000000000000;
    localparam logic [63:0] C_NZ   = 64'h8000000000000000;
    localparam logic [63:0] C_PINF = 64'h7FF0000000000000;
    localparam logic [63:0] C_NINF = 64'hFFF0000000000000;
    localparam logic [63:0] C_QN   = 64'h7FF8000000000000;
    localparam logic [63:0] C_SN   = 64'h7FF0000000000001;
    localparam logic [63:0] C_NSN  = 64'hFFF4000000000000;
    localparam logic [63:0] C_DEN  = 64'h0000000000000001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b11;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        ve_en = 1'b0;
    logic        ze_en = 1'b0;
    logic        rnd_fr = 1'b0;
    logic        rnd_fi = 1'b0;
    logic fx, vx, vx_snan, vx_zdz, vx_idi, vx_sqrt, zx, fr, fi, dest_we, fprf_we;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    bit m_fx, m_vx, m_snan, m_zdz, m_idi, m_sqrt, m_zx, m_fr, m_fi, m_dw, m_pw;

    always #2.5 clk = ~clk;

    fdx_flag_unit u_fdx_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .dividend(dividend), .divisor(divisor), .ve_en(ve_en), .ze_en(ze_en),
        .rnd_fr(rnd_fr), .rnd_fi(rnd_fi), .fx(fx), .vx(vx), .vx_snan(vx_snan),
        .vx_zdz(vx_zdz), .vx_idi(vx_idi), .vx_sqrt(vx_sqrt), .zx(zx), .fr(fr),
        .fi(fi), .dest_we(dest_we), .fprf_we(fprf_we)
    );

    // R1 classification, written from the requirement text
    function automatic bit is_inf(logic [63:0] x);
        return x[62:52] == 11'h7FF && x[51:0] == 0;
    endfunction
    function automatic bit is_nan(logic [63:0] x);
        return x[62:52] == 11'h7FF && x[51:0] != 0;
    endfunction
    function automatic bit is_snan(logic [63:0] x);
        return is_nan(x) && x[51] == 1'b0;
    endfunction
    function automatic bit is_zero(logic [63:0] x);
        return x[62:0] == 0;
    endfunction
    function automatic bit is_fin(logic [63:0] x);
        return x[62:52] != 11'h7FF && !is_zero(x);
    endfunction

    always @(posedge clk) begin
        bit e_snan, e_zdz, e_idi, e_sqrt, e_zx, e_inv, any_nan, rise;
        if (!rst_n) begin
            {m_fx, m_vx, m_snan, m_zdz, m_idi, m_sqrt, m_zx, m_fr, m_fi, m_dw, m_pw} = '0;
        end else begin
            m_dw = 0; m_pw = 0;
            if (op_valid && op_kind != 2'b11) begin
                e_snan = 0; e_zdz = 0; e_idi = 0; e_sqrt = 0; e_zx = 0;
                if (op_kind == 2'b00) begin
                    e_snan = is_snan(dividend) || is_snan(divisor);
                    any_nan = is_nan(dividend) || is_nan(divisor);
                    if (!any_nan) begin
                        e_zdz = is_zero(dividend) && is_zero(divisor);
                        e_idi = is_inf(dividend) && is_inf(divisor);
                        e_zx  = is_fin(dividend) && is_zero(divisor);
                    end
                end else begin
                    e_snan = is_snan(divisor);
                    e_zx   = is_zero(divisor);
                    if (op_kind == 2'b10)
                        e_sqrt = divisor[63] && (is_fin(divisor) || is_inf(divisor));
                end
                e_inv = e_snan || e_zdz || e_idi || e_sqrt;
                rise = (e_snan && !m_snan) || (e_zdz && !m_zdz) || (e_idi && !m_idi)
                    || (e_sqrt && !m_sqrt) || (e_zx && !m_zx);
                m_snan |= e_snan; m_zdz |= e_zdz; m_idi |= e_idi; m_sqrt |= e_sqrt;
                m_zx |= e_zx; m_vx |= e_inv; m_fx |= rise;
                if (e_zx || e_inv) begin m_fr = 0; m_fi = 0; end
                else begin m_fr = rnd_fr; m_fi = rnd_fi; end
                m_dw = !((ve_en && e_inv) || (ze_en && e_zx));
                m_pw = m_dw;
            end
        end
    end

    task automatic check(input logic act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            check(zx, m_zx, "R2", "zx");
            check(vx_zdz, m_zdz, "R4", "vx_zdz");
            check(vx_idi, m_idi, "R4", "vx_idi");
            check(vx_snan, m_snan, "R5", "vx_snan");
            check(vx_sqrt, m_sqrt, "R6", "vx_sqrt");
            check(vx, m_vx, "R7", "vx");
            check(fx, m_fx, "R8", "fx");
            check(fr, m_fr, "R9", "fr");
            check(fi, m_fi, "R9", "fi");
            check(dest_we, m_dw, "R10", "dest_we");
            check(fprf_we, m_pw, "R10", "fprf_we");
        end
    end

    // drive at a falling edge, return at the falling edge where outputs reflect it
    task automatic do_op(input logic [1:0] k, input logic [63:0] a, input logic [63:0] b,
                         input bit ve, input bit ze, input bit rfr, input bit rfi);
        op_valid = 1; op_kind = k; dividend = a; divisor = b;
        ve_en = ve; ze_en = ze; rnd_fr = rfr; rnd_fi = rfi;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #(1_000_000);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] pool [11];
        pool = '{C_P1, C_P2, C_N4, C_PZ, C_NZ, C_PINF, C_NINF, C_QN, C_SN, C_NSN, C_DEN};
        @(negedge clk);
        @(posedge clk);
        started = 1;
        @(negedge clk);
        // R12 reset state
        check(fx | vx | vx_snan | vx_zdz | vx_idi | vx_sqrt | zx | fr | fi | dest_we | fprf_we,
              1'b0, "R12", "all outputs after reset");
        rst_n = 1;
        @(negedge clk);

        do_op(2'b00, C_P1, C_P2, 0, 0, 1, 1);          // plain divide
        check(dest_we, 1'b1, "R10", "normal write");
        check(fr & fi, 1'b1, "R9", "rounding flags loaded");
        @(negedge clk);                                  // idle: R9 hold, R10 pulse ends
        check(fr, 1'b1, "R9", "fr held when idle");
        do_op(2'b11, C_PZ, C_PZ, 0, 0, 0, 0);           // R11 reserved kind
        check(vx_zdz | dest_we, 1'b0, "R11", "reserved kind ignored");
        check(fr, 1'b1, "R11", "fr untouched by reserved kind");
        do_op(2'b00, C_QN, C_PZ, 0, 0, 0, 1);           // R5 quiet NaN suppresses zx
        check(zx, 1'b0, "R5", "qnan over zero no zx");
        check(vx_snan, 1'b0, "R1", "quiet NaN not signaling");
        do_op(2'b00, C_PINF, C_PZ, 0, 0, 0, 0);         // inf / 0: not finite, no event
        check(zx, 1'b0, "R1", "infinity not finite");
        do_op(2'b01, C_P1, C_NZ, 0, 0, 1, 1);           // R3 recip estimate of -0
        check(zx, 1'b1, "R3", "recip estimate zero");
        check(fr | fi, 1'b0, "R9", "zero-divide clears rounding");
        check(fx, 1'b1, "R8", "fx on first zx");
        do_op(2'b00, C_NZ, C_PZ, 1, 0, 1, 1);           // R4 0/0 trapped
        check(vx_zdz, 1'b1, "R4", "0/0 sets vx_zdz");
        check(dest_we | fprf_we, 1'b0, "R10", "ve blocks writes");
        do_op(2'b00, C_NINF, C_PINF, 0, 0, 0, 0);       // R4 inf/inf
        check(vx_idi, 1'b1, "R4", "inf/inf");

        do_reset();
        do_op(2'b00, C_PZ, C_NZ, 0, 0, 0, 0);           // R4 0/0 alone: no zx
        check(zx, 1'b0, "R4", "0/0 leaves zx");
        check(vx, 1'b1, "R7", "vx summary");
        do_op(2'b00, C_DEN, C_PZ, 0, 1, 1, 0);          // R2 denormal / 0 with ZE
        check(zx, 1'b1, "R2", "denormal over zero");
        check(fprf_we, 1'b0, "R10", "ze blocks fprf");
        do_op(2'b10, C_P1, C_N4, 0, 0, 0, 0);           // R6
        check(vx_sqrt, 1'b1, "R6", "rsqrt negative");
        do_op(2'b00, C_P1, C_SN, 0, 0, 0, 0);           // R1 / R5 signaling divisor
        check(vx_snan, 1'b1, "R1", "signaling NaN classified");
        check(dest_we, 1'b1, "R5", "snan untrapped writes");
        do_op(2'b00, C_P1, C_P2, 0, 0, 1, 0);
        check(fx & zx, 1'b1, "R8", "sticky bits persist");

        do_reset();
        do_op(2'b10, C_NSN, C_NSN, 1, 0, 0, 0);         // R5/R6 negative sNaN: no sqrt
        check(vx_sqrt, 1'b0, "R6", "negative NaN no sqrt");
        check(vx_snan, 1'b1, "R5", "negative sNaN");

        for (int i = 0; i < 600; i++) begin
            if (i % 75 == 0) do_reset();
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk);
            end else begin
                do_op(2'($urandom_range(0, 3)), pool[$urandom_range(0, 10)],
                      pool[$urandom_range(0, 10)], 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
            end
        end
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule